// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a memory-mapped timer built around one free-running counter. The counter is 32 or 64 bits wide, set by a parameter. Several tick-enable inputs, all synchronous to the one system clock, stand in for the different timebases. A single configuration word chooses one of them, divides it by an 8-bit factor plus one, and gates the whole path with an enable bit. Each pulse that leaves the divider advances the counter by one. The counter wraps to zero after its largest value.

A compare register holds a target value. When a divided pulse carries the counter onto that value, a sticky pending flag is set. The level interrupt output follows the flag until software writes 0x3 to the status register. Software reaches all state through a single-cycle write strobe and a read strobe. Read data comes back one cycle after the read strobe and is marked by a valid flag. Each 32-bit half of the counter and of the compare value can be loaded on its own.

Top module: `cmp_timer`

## Requirements
- R1: After reset the configuration, count, compare and status registers read as zero, and irq_o and reg_rvalid are low.
- R2: While configuration bit 0 (enable) is 0, the counter holds its value except when software loads it.
- R3: With prescale factor N in configuration bits 31:24, the counter advances once for every N+1 ticks of the selected source. Code 0 ticks on every clock, so with N=47 and a continuous source, 96 ticks give a count of 2.
- R4: Configuration bits 23:20 select the source. Code 0 is the system clock. Codes 1, 3, 4, 5, 8 and 9 take fixed_tick_i bits 0, 1, 2, 3, 4 and 5 in that order. Code 2 takes the auxiliary group. Codes 6, 7 and 10–15 never advance the counter.
- R5: Configuration bits 10:8 pick which alt_tick_i bit drives code 2. With any other source code they have no effect.
- R6: Configuration bit 11 always reads 0, and writes to it are dropped. All other configuration bits read back as written.
- R7: Register offsets in the 64-bit build are: count low 0x00, count high 0x04, compare low 0x08, compare high 0x0C, status 0x18, configuration 0x1C. In the 32-bit build they are: compare 0x0, count 0x4, configuration 0x8, status 0x14.
- R8: A divided pulse that makes the counter equal to the compare value sets the pending flag (status bit 0). irq_o equals that flag and stays high until it is cleared.
- R9: Writing exactly 0x3 in status bits 1:0 clears the pending flag. Any other value leaves it set.
- R10: The counter wraps from all ones to zero and keeps counting. Reaching a compare value of zero through the wrap sets the pending flag.
- R11: Any configuration write restarts the divider, so the first advance comes a full N+1 source ticks after the write.
- R12: A write to a count half loads that half directly and leaves the other half unchanged.
- R13: reg_rvalid is high in the cycle after reg_re, and reg_rdata then holds the register value as it was at the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_tick_i | input | 6 | Tick enables for source codes 1, 3, 4, 5, 8, 9 |
| alt_tick_i | input | 8 | Tick enables for source code 2, chosen by the sub-select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset inside the 4 KB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_re |
| irq_o | output | 1 | Level interrupt, the pending flag |

## Verification
The bench builds the block with a 64-bit counter and a 12-bit address. That build exposes the split register halves, so it can show that loading one half of the count leaves the other untouched. It also makes it possible to preload the count to just below all ones and watch it wrap into a zero compare value. The default 8-bit prescaler lets the bench use the divide-by-48 setting directly. The source table drives every ticking code, several dead codes and the sub-selected auxiliary lines against lines that should be ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PF_W     = 8;
  localparam int SRC_W    = 4;
  localparam int SUB_W    = 3;
  localparam int N_FIXED  = 6;
  localparam int N_ALT    = 1 << SUB_W;
  localparam int WORD_W   = 32;

  // configuration word layout, most significant field first
  typedef struct packed {
    logic [PF_W-1:0]  pf;
    logic [SRC_W-1:0] src;
    logic [7:0]       spare_hi;
    logic             raz;
    logic [SUB_W-1:0] sub;
    logic [6:0]       spare_lo;
    logic             en;
  } cfg_t;

  localparam int RAZ_BIT = 11;

  function automatic int off_cnt(input bit lng);
    return lng ? 'h00 : 'h04;
  endfunction

  function automatic int off_cmp(input bit lng);
    return lng ? 'h08 : 'h00;
  endfunction

  function automatic int off_cfg(input bit lng);
    return lng ? 'h1C : 'h08;
  endfunction

  function automatic int off_sts(input bit lng);
    return lng ? 'h18 : 'h14;
  endfunction

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
(
  input  logic [SRC_W-1:0]   src_code,
  input  logic [SUB_W-1:0]   sub_code,
  input  logic [N_FIXED-1:0] fixed_tick,
  input  logic [N_ALT-1:0]   alt_tick,
  output logic               tick
);

  always_comb begin
    unique case (src_code)
      4'd0:    tick = 1'b1;
      4'd1:    tick = fixed_tick[0];
      4'd2:    tick = alt_tick[sub_code];
      4'd3:    tick = fixed_tick[1];
      4'd4:    tick = fixed_tick[2];
      4'd5:    tick = fixed_tick[3];
      4'd8:    tick = fixed_tick[4];
      4'd9:    tick = fixed_tick[5];
      default: tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            restart,
  input  logic            tick,
  input  logic [PF_W-1:0] factor,
  output logic            adv
);

  logic [PF_W-1:0] div_q;
  logic [PF_W-1:0] div_d;
  logic            hit;

  assign hit = (div_q == factor);
  assign adv = enable && tick && hit;

  always_comb begin
    if (restart || !enable) begin
      div_d = '0;
    end else if (tick) begin
      div_d = hit ? '0 : div_q + 1'b1;
    end else begin
      div_d = div_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [CNT_W/WORD_W-1:0] cnt_wr,
  input  logic [CNT_W/WORD_W-1:0] cmp_wr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  clr_req,
  output logic [CNT_W-1:0]      cnt_q,
  output logic [CNT_W-1:0]      cmp_q,
  output logic                  pend_q
);

  localparam int NH = CNT_W / WORD_W;

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cmp_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             pend_d;
  logic             hit_set;

  assign cnt_inc = cnt_q + 1'b1;
  assign hit_set = adv && !(|cnt_wr) && (cnt_inc == cmp_q);

  always_comb begin
    cnt_d = adv ? cnt_inc : cnt_q;
    cmp_d = cmp_q;
    for (int h = 0; h < NH; h++) begin
      if (cnt_wr[h]) cnt_d[h*WORD_W +: WORD_W] = wr_data;
      if (cmp_wr[h]) cmp_d[h*WORD_W +: WORD_W] = wr_data;
    end
  end

  always_comb begin
    if (hit_set) begin
      pend_d = 1'b1;
    end else if (clr_req) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FIXED-1:0] fixed_tick_i,
  input  logic [N_ALT-1:0]   alt_tick_i,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               irq_o
);

  localparam bit LONG    = (CNT_W > WORD_W);
  localparam int NH      = CNT_W / WORD_W;
  localparam int OFF_CNT = off_cnt(LONG);
  localparam int OFF_CMP = off_cmp(LONG);
  localparam int OFF_CFG = off_cfg(LONG);
  localparam int OFF_STS = off_sts(LONG);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // register decode
  logic             cfg_wr, sts_clr;
  logic [NH-1:0]    cnt_wr, cmp_wr;

  assign cfg_wr  = reg_we && (reg_addr == ADDR_W'(OFF_CFG));
  assign sts_clr = reg_we && (reg_addr == ADDR_W'(OFF_STS)) && (reg_wdata[1:0] == 2'b11);

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign cnt_wr[h] = reg_we && (reg_addr == ADDR_W'(OFF_CNT + 4*h));
    assign cmp_wr[h] = reg_we && (reg_addr == ADDR_W'(OFF_CMP + 4*h));
  end

  // configuration register
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) begin
      cfg_d     = cfg_t'(reg_wdata);
      cfg_d.raz = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // tick path
  logic src_tick, adv;

  tmr_src_sel u_src_sel (
    .src_code   (cfg_q.src),
    .sub_code   (cfg_q.sub),
    .fixed_tick (fixed_tick_i),
    .alt_tick   (alt_tick_i),
    .tick       (src_tick)
  );

  tmr_prescale #(.PF_W(PF_W)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .enable  (cfg_q.en),
    .restart (cfg_wr),
    .tick    (src_tick),
    .factor  (cfg_q.pf),
    .adv     (adv)
  );

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             pend_q;

  tmr_core #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .adv     (adv),
    .cnt_wr  (cnt_wr),
    .cmp_wr  (cmp_wr),
    .wr_data (reg_wdata),
    .clr_req (sts_clr),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .pend_q  (pend_q)
  );

  assign irq_o = pend_q;

  // read port, one cycle of latency
  logic [WORD_W-1:0] rd_d, rdata_q;
  logic              rvalid_q;

  always_comb begin
    rd_d = '0;
    for (int h = 0; h < NH; h++) begin
      if (reg_addr == ADDR_W'(OFF_CNT + 4*h)) rd_d = cnt_q[h*WORD_W +: WORD_W];
      if (reg_addr == ADDR_W'(OFF_CMP + 4*h)) rd_d = cmp_q[h*WORD_W +: WORD_W];
    end
    if (reg_addr == ADDR_W'(OFF_CFG)) rd_d = cfg_q;
    if (reg_addr == ADDR_W'(OFF_STS)) rd_d = {{(WORD_W-1){1'b0}}, pend_q};
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_re;
      if (reg_re) rdata_q <= rd_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        wdata_lo,
  input logic              reg_rvalid,
  input logic              irq_o,
  input logic              cfg_en,
  input logic [SRC_W-1:0]  cfg_src,
  input logic              cfg_raz,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              adv
);

  localparam bit LONG = (CNT_W > WORD_W);

  logic cnt_load, clr_hit, cfg_hit, dead_src;

  assign cnt_load = reg_we && ((reg_addr == ADDR_W'(off_cnt(LONG))) ||
                               (LONG && (reg_addr == ADDR_W'(off_cnt(LONG) + 4))));
  assign clr_hit  = reg_we && (reg_addr == ADDR_W'(off_sts(LONG))) && (wdata_lo == 2'b11);
  assign cfg_hit  = reg_we && (reg_addr == ADDR_W'(off_cfg(LONG)));
  assign dead_src = (cfg_src == 4'd6) || (cfg_src == 4'd7) || (cfg_src >= 4'd10);

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cnt_load) |=> $stable(cnt_q));

  // R4
  dead_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_src && !cnt_load) |=> $stable(cnt_q));

  // R6
  raz_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> !cfg_raz);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_hit) |=> irq_o);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !adv) |=> !irq_o);

  // R10
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cnt_load) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R13
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> reg_rvalid);

  // R13
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> !reg_rvalid);

endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tmr_chk (
  .clk        (clk),
  .rst_n      (rst_sync_q),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .reg_addr   (reg_addr),
  .wdata_lo   (reg_wdata[1:0]),
  .reg_rvalid (reg_rvalid),
  .irq_o      (irq_o),
  .cfg_en     (cfg_q.en),
  .cfg_src    (cfg_q.src),
  .cfg_raz    (cfg_q.raz),
  .cnt_q      (cnt_q),
  .adv        (adv)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 64;
  localparam int ADDR_W     = 12;

  localparam logic [11:0] A_CNT_LO = 12'h000;
  localparam logic [11:0] A_CNT_HI = 12'h004;
  localparam logic [11:0] A_CMP_LO = 12'h008;
  localparam logic [11:0] A_CMP_HI = 12'h00C;
  localparam logic [11:0] A_STS    = 12'h018;
  localparam logic [11:0] A_CFG    = 12'h01C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  fixed_tick;
  logic [7:0]  alt_tick;
  logic        reg_we, reg_re;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cmp_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .fixed_tick_i (fixed_tick),
    .alt_tick_i   (alt_tick),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .reg_rvalid   (reg_rvalid),
    .irq_o        (irq)
  );

  // cfg, fixed mask, alt mask, window length, expected count
  typedef struct packed {
    logic [31:0] cfg;
    logic [5:0]  fm;
    logic [7:0]  am;
    logic [7:0]  len;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0001, 6'h00, 8'h00, 8'd10, 8'd10}, // R3 R4 code 0, N=0
    '{32'h0300_0001, 6'h00, 8'h00, 8'd10, 8'd2 }, // R3 N=3
    '{32'h0010_0001, 6'h01, 8'h00, 8'd7,  8'd7 }, // R4 code 1 on bit 0
    '{32'h0010_0001, 6'h3E, 8'hFF, 8'd7,  8'd0 }, // R4 code 1, other lines only
    '{32'h0130_0001, 6'h02, 8'h00, 8'd9,  8'd4 }, // R3 R4 code 3, N=1
    '{32'h0090_0001, 6'h20, 8'h00, 8'd5,  8'd5 }, // R4 code 9 on bit 5
    '{32'h0020_0501, 6'h00, 8'h20, 8'd6,  8'd6 }, // R5 code 2, sub 5
    '{32'h0020_0501, 6'h3F, 8'hDF, 8'd6,  8'd0 }, // R5 code 2, sub line low
    '{32'h0060_0001, 6'h3F, 8'hFF, 8'd6,  8'd0 }, // R4 dead code 6
    '{32'h00C0_0001, 6'h3F, 8'hFF, 8'd6,  8'd0 }, // R4 dead code 12
    '{32'h0000_0000, 6'h3F, 8'hFF, 8'd6,  8'd0 }, // R2 disabled
    '{32'h0280_0001, 6'h10, 8'h00, 8'd12, 8'd4 }, // R3 R4 code 8, N=2
    '{32'h0040_0501, 6'h3B, 8'hFF, 8'd6,  8'd0 }, // R5 sub ignored off code 2
    '{32'h0050_0001, 6'h08, 8'h00, 8'd4,  8'd4 }  // R4 code 5 on bit 3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    v = reg_rvalid;
    d = reg_rdata;
  endtask

  // count enabled for exactly len edges after the configuration write
  task automatic window(input logic [31:0] cfg, input logic [5:0] fm,
                        input logic [7:0] am, input int len);
    fixed_tick = fm; alt_tick = am;
    wr(A_CFG, cfg);
    repeat (len - 1) @(negedge clk);
    wr(A_CFG, 32'h0);
    fixed_tick = '0; alt_tick = '0;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        v;
    rst_n = 1'b0; fixed_tick = '0; alt_tick = '0;
    reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rvalid", {31'b0, reg_rvalid}, 32'h0);
    rd(A_CFG, d, v);    check("R1 cfg", d, 32'h0);
    check("R13 rvalid after read", {31'b0, v}, 32'h1);
    rd(A_CNT_LO, d, v); check("R1 count", d, 32'h0);
    rd(A_STS, d, v);    check("R1 status", d, 32'h0);

    // source / prescale table (R2 R3 R4 R5)
    wr(A_CMP_LO, 32'hFFFF_FFFF);
    wr(A_CMP_HI, 32'hFFFF_FFFF);
    for (int i = 0; i < NV; i++) begin
      wr(A_CNT_LO, 32'h0);
      wr(A_CNT_HI, 32'h0);
      window(VEC[i].cfg, VEC[i].fm, VEC[i].am, int'(VEC[i].len));
      rd(A_CNT_LO, d, v);
      check($sformatf("R2/R3/R4/R5 table vector %0d", i), d, {24'h0, VEC[i].exp});
    end

    // R6 bit 11 reads as zero
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d, v); check("R6 all ones", d, 32'hFFFF_F7FF);
    wr(A_CFG, 32'h0000_0800);
    rd(A_CFG, d, v); check("R6 bit 11 only", d, 32'h0);

    // R3 divide by 48 on code 3
    wr(A_CNT_LO, 32'h0);
    wr(A_CFG, 32'h2F34_500D);
    rd(A_CFG, d, v); check("R6 readback", d, 32'h2F34_500D);
    wr(A_CFG, 32'h0);
    window(32'h2F34_500D, 6'h02, 8'h00, 96);
    rd(A_CNT_LO, d, v); check("R3 divide by 48", d, 32'd2);

    // R11 rewrite restarts the divider
    wr(A_CNT_LO, 32'h0);
    wr(A_CFG, 32'h0300_0001);
    @(negedge clk);
    wr(A_CFG, 32'h0300_0001);
    repeat (2) @(negedge clk);
    wr(A_CFG, 32'h0);
    rd(A_CNT_LO, d, v); check("R11 divider restart", d, 32'h0);

    // R7 R12 halves load independently
    wr(A_CNT_LO, 32'h0000_1234);
    wr(A_CNT_HI, 32'h0000_000A);
    rd(A_CNT_LO, d, v); check("R12 low half kept", d, 32'h0000_1234);
    rd(A_CNT_HI, d, v); check("R7 count high", d, 32'h0000_000A);
    wr(A_CMP_LO, 32'h0000_0005);
    wr(A_CMP_HI, 32'h0000_0000);
    rd(A_CMP_LO, d, v); check("R7 compare low", d, 32'h5);
    rd(A_CMP_HI, d, v); check("R7 compare high", d, 32'h0);

    // R8 compare hit, R9 clear
    wr(A_CNT_LO, 32'h0);
    wr(A_CNT_HI, 32'h0);
    wr(A_CFG, 32'h0000_0001);
    repeat (4) @(negedge clk);
    check("R8 irq before hit", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq on hit", {31'b0, irq}, 32'h1);
    wr(A_CFG, 32'h0);
    repeat (3) @(negedge clk);
    check("R8 irq held", {31'b0, irq}, 32'h1);
    rd(A_STS, d, v); check("R8 status bit", d, 32'h1);
    wr(A_STS, 32'h1);
    check("R9 partial clear ignored", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h3);
    check("R9 clear", {31'b0, irq}, 32'h0);

    // R10 wrap through zero compare
    wr(A_CMP_LO, 32'h0);
    wr(A_CNT_LO, 32'hFFFF_FFFE);
    wr(A_CNT_HI, 32'hFFFF_FFFF);
    window(32'h0000_0001, 6'h00, 8'h00, 3);
    rd(A_CNT_LO, d, v); check("R10 wrap low", d, 32'h1);
    rd(A_CNT_HI, d, v); check("R10 wrap high", d, 32'h0);
    check("R10 irq at zero", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h3);

    finish_run();
  end

endmodule